// File: doc/BRIEF.md
# Two-Lane Interleaved Quadrature NCO

This block is a numerically controlled oscillator that produces quadrature (sine and cosine) samples at twice the rate of its own clock. It does so with two lanes that each deliver one sample pair per clock. The even lane carries samples 0, 2, 4 and so on of a notional double-rate oscillator. The odd lane carries samples 1, 3, 5 and so on. A downstream mixer that receives a two-way demultiplexed converter stream can multiply each lane against its matching input lane directly.

The frequency is set by a full-rate phase increment loaded through a word port. Both lanes share one 32-bit accumulator, and that accumulator advances by twice the increment on each enabled clock. The odd lane adds one increment (half the lane step) to the accumulator before its table lookup. A newly loaded increment changes only the step and never resets the accumulator, so the phase stays continuous across frequency hops and sweeps. The lookup takes the top 10 phase bits and reads a full-cycle sine table that is computed when the design is elaborated. The cosine is read from the same table, a quarter cycle ahead.

Top module: `dual_lane_nco`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and all four sample outputs are 0.
- R2: The even-lane phase of the k-th enabled clock after reset is 2·k·F mod 2^32, where F is the loaded increment. The accumulator advances by 2·F only on clocks where ce is 1.
- R3: The odd-lane phase of each sample equals the even-lane phase of that sample plus F, mod 2^32.
- R4: For a phase p, the index is p[31:22]. The sine output is floor(131071·sin(2π·idx/1024)+0.5). The cosine output is the sine entry at (idx+256) mod 1024. The outputs are signed 18-bit values.
- R5: A sample whose phase is taken on a clock with ce=1 appears at the outputs two rising edges later, with out_valid=1 in that same cycle.
- R6: On a clock with ce=0, the accumulator holds. Two edges later, out_valid is 0 and the four sample outputs keep their previous values.
- R7: When freq_load is 1 on an edge, freq_word becomes F from the next edge onward, for both lanes at once. The accumulator is not cleared, so the phase stays continuous. A load during ce=0 takes effect in the same way.
- R8: Asserting rst in the middle of operation clears the accumulator and the increment. Sampling then restarts from phase 0.
- R9: Phase arithmetic wraps modulo 2^32 without saturating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock (half the output sample rate) |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for phase advance and sample production |
| freq_load | input | 1 | Captures freq_word as the new full-rate increment |
| freq_word | input | 32 | Full-rate phase increment |
| sin_even | output | 18 | Even-lane sine sample, signed |
| cos_even | output | 18 | Even-lane cosine sample, signed |
| sin_odd | output | 18 | Odd-lane sine sample, signed |
| cos_odd | output | 18 | Odd-lane cosine sample, signed |
| out_valid | output | 1 | Four sample outputs carry a new pair of samples |

## Verification
The bench focuses on frequency loads that land in the middle of a run, including loads made while ce is low. A design that cleared the accumulator on a load, or that let the odd lane pick up the new increment one clock before or after the even lane, would produce a phase step. That step shows up as wrong table values on the next output. Gaps in ce check that the outputs hold and that the valid flag falls with the right two-clock delay. A design that advanced during a gap would drift by 2·F. Large increments force the accumulator and the odd-lane adder to wrap, and a mid-run reset checks the restart from phase 0.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int PHASE_W = 32;
  localparam int IDX_W   = 10;
  localparam int AMP_W   = 18;

  typedef logic [PHASE_W-1:0]      phase_t;
  typedef logic signed [AMP_W-1:0] amp_t;
endpackage

// File: rtl/nco_freq_reg.sv
module nco_freq_reg #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [PHASE_W-1:0] word,
  output logic [PHASE_W-1:0] step_q
);
  // Single holding register read by both lanes: a new word reaches them on one edge.
  always_ff @(posedge clk) begin
    if (rst)       step_q <= '0;
    else if (load) step_q <= word;
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] acc_q,
  output logic [PHASE_W-1:0] ph_even_q,
  output logic [PHASE_W-1:0] ph_odd_q,
  output logic               ph_valid_q
);
  logic [PHASE_W-1:0] lane_step;
  logic [PHASE_W-1:0] odd_phase;

  // Each lane moves two full-rate steps per clock; odd lane sits one step ahead.
  assign lane_step = {step[PHASE_W-2:0], 1'b0};
  assign odd_phase = acc_q + step;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      ph_even_q  <= '0;
      ph_odd_q   <= '0;
      ph_valid_q <= 1'b0;
    end else begin
      ph_valid_q <= ce;
      if (ce) begin
        acc_q     <= acc_q + lane_step;
        ph_even_q <= acc_q;
        ph_odd_q  <= odd_phase;
      end
    end
  end
endmodule

// File: rtl/nco_sincos_rom.sv
module nco_sincos_rom #(
  parameter int IDX_W = 10,
  parameter int AMP_W = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [IDX_W-1:0]        idx,
  output logic signed [AMP_W-1:0] sin_q,
  output logic signed [AMP_W-1:0] cos_q
);
  localparam int DEPTH   = 1 << IDX_W;
  localparam int QUARTER = DEPTH / 4;
  localparam int PEAK    = (1 << (AMP_W - 1)) - 1;

  logic signed [AMP_W-1:0] tbl [DEPTH];
  logic [IDX_W-1:0]        cos_idx;

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      real ang;
      ang    = 6.283185307179586 * real'(k) / real'(DEPTH);
      tbl[k] = AMP_W'($rtoi($floor(real'(PEAK) * $sin(ang) + 0.5)));
    end
  end

  assign cos_idx = idx + IDX_W'(QUARTER);

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_q <= '0;
      cos_q <= '0;
    end else if (en) begin
      sin_q <= tbl[idx];
      cos_q <= tbl[cos_idx];
    end
  end
endmodule

// File: rtl/dual_lane_nco.sv
module dual_lane_nco
  import nco_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int IW = IDX_W,
  parameter int AW = AMP_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic                 freq_load,
  input  logic [PW-1:0]        freq_word,
  output logic signed [AW-1:0] sin_even,
  output logic signed [AW-1:0] cos_even,
  output logic signed [AW-1:0] sin_odd,
  output logic signed [AW-1:0] cos_odd,
  output logic                 out_valid
);
  localparam int LANES = 2;

  logic [PW-1:0] step_q;
  logic [PW-1:0] acc_q;
  logic [PW-1:0] ph_even_q;
  logic [PW-1:0] ph_odd_q;
  logic          ph_valid_q;

  logic [PW-1:0]        lane_ph  [LANES];
  logic signed [AW-1:0] lane_sin [LANES];
  logic signed [AW-1:0] lane_cos [LANES];

  nco_freq_reg #(.PHASE_W(PW)) u_freq (
    .clk    (clk),
    .rst    (rst),
    .load   (freq_load),
    .word   (freq_word),
    .step_q (step_q)
  );

  nco_phase_acc #(.PHASE_W(PW)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .ce         (ce),
    .step       (step_q),
    .acc_q      (acc_q),
    .ph_even_q  (ph_even_q),
    .ph_odd_q   (ph_odd_q),
    .ph_valid_q (ph_valid_q)
  );

  assign lane_ph[0] = ph_even_q;
  assign lane_ph[1] = ph_odd_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    nco_sincos_rom #(.IDX_W(IW), .AMP_W(AW)) u_rom (
      .clk   (clk),
      .rst   (rst),
      .en    (ph_valid_q),
      .idx   (lane_ph[g][PW-1 -: IW]),
      .sin_q (lane_sin[g]),
      .cos_q (lane_cos[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= ph_valid_q;
  end

  assign sin_even = lane_sin[0];
  assign cos_even = lane_cos[0];
  assign sin_odd  = lane_sin[1];
  assign cos_odd  = lane_cos[1];
endmodule

// File: rtl/dual_lane_nco_checker.sv
module dual_lane_nco_checker #(
  parameter int PW = 32,
  parameter int AW = 18
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ce,
  input logic                 freq_load,
  input logic [PW-1:0]        freq_word,
  input logic [PW-1:0]        step_q,
  input logic [PW-1:0]        acc_q,
  input logic                 ph_valid_q,
  input logic signed [AW-1:0] sin_even,
  input logic signed [AW-1:0] sin_odd,
  input logic                 out_valid
);
  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !out_valid);

  assert_acc_advance_R2: assert property (@(posedge clk) disable iff (rst)
    ce |=> acc_q == $past(acc_q) + {$past(step_q[PW-2:0]), 1'b0});

  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (rst)
    ce |=> ##1 out_valid);

  assert_gap_invalid_R6: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ##1 !out_valid);

  assert_gap_hold_acc_R6: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(acc_q));

  assert_gap_hold_out_R6: assert property (@(posedge clk) disable iff (rst)
    !ph_valid_q |=> $stable(sin_even) && $stable(sin_odd));

  assert_freq_capture_R7: assert property (@(posedge clk) disable iff (rst)
    freq_load |=> step_q == $past(freq_word));

  assert_freq_keep_R7: assert property (@(posedge clk) disable iff (rst)
    !freq_load |=> $stable(step_q));
endmodule

bind dual_lane_nco dual_lane_nco_checker #(.PW(PW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ce         (ce),
  .freq_load  (freq_load),
  .freq_word  (freq_word),
  .step_q     (step_q),
  .acc_q      (acc_q),
  .ph_valid_q (ph_valid_q),
  .sin_even   (sin_even),
  .sin_odd    (sin_odd),
  .out_valid  (out_valid)
);

// File: tb/dual_lane_nco_tb.sv
module dual_lane_nco_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PEAK = 131071;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               ce = 1'b0;
  logic               freq_load = 1'b0;
  logic [31:0]        freq_word = '0;
  logic signed [17:0] sin_even, cos_even, sin_odd, cos_odd;
  logic               out_valid;

  int checks = 0;
  int fails  = 0;
  string ctx = "R1";

  // reference model state
  bit [31:0] m_acc = 0;
  bit [31:0] m_inc = 0;
  int        e_se = 0, e_ce = 0, e_so = 0, e_co = 0;
  bit        e_v = 0;
  bit [31:0] pend_e [$];
  bit [31:0] pend_o [$];
  bit        pend_v [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_lane_nco u_dut (
    .clk(clk), .rst(rst), .ce(ce), .freq_load(freq_load), .freq_word(freq_word),
    .sin_even(sin_even), .cos_even(cos_even), .sin_odd(sin_odd), .cos_odd(cos_odd),
    .out_valid(out_valid)
  );

  function automatic int ref_sin(input int idx);
    real a;
    a = 6.283185307179586 * real'(idx % 1024) / 1024.0;
    return $rtoi($floor(real'(PEAK) * $sin(a) + 0.5));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, ctx, act, exp, $time);
    end
  endtask

  // one clock: inputs applied at negedge, model stepped at posedge, outputs compared at next negedge
  task automatic cyc(input bit r, input bit c, input bit ld, input bit [31:0] w);
    rst = r; ce = c; freq_load = ld; freq_word = w;
    @(posedge clk);
    if (r) begin
      m_acc = 0; m_inc = 0;
      pend_e.delete(); pend_o.delete(); pend_v.delete();
      e_v = 0; e_se = 0; e_ce = 0; e_so = 0; e_co = 0;
    end else begin
      if (pend_v.size() > 0) begin
        bit v; bit [31:0] pe, po;
        v = pend_v.pop_front(); pe = pend_e.pop_front(); po = pend_o.pop_front();
        e_v = v;
        if (v) begin
          e_se = ref_sin(int'(pe[31:22]));
          e_ce = ref_sin(int'(pe[31:22]) + 256);
          e_so = ref_sin(int'(po[31:22]));
          e_co = ref_sin(int'(po[31:22]) + 256);
        end
      end
      pend_v.push_back(c);
      pend_e.push_back(m_acc);
      pend_o.push_back(m_acc + m_inc);
      if (c)  m_acc = m_acc + 2 * m_inc;
      if (ld) m_inc = w;
    end
    @(negedge clk);
    check("R5", int'(out_valid), int'(e_v));
    check("R2", int'(sin_even), e_se);
    check("R4", int'(cos_even), e_ce);
    check("R3", int'(sin_odd), e_so);
    check("R4", int'(cos_odd), e_co);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    ctx = "R1";
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    // R1: idle after reset, zero outputs
    check("R1", int'(out_valid), 0);
    check("R1", int'(sin_even) | int'(cos_odd), 0);

    ctx = "R2";
    cyc(0, 0, 1, 32'h0123_4567);
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, 0);

    ctx = "R6";
    for (int i = 0; i < 30; i++) cyc(0, (i % 3) != 1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);

    ctx = "R7";
    for (int i = 0; i < 20; i++) cyc(0, 1, (i % 5) == 2, 32'h0400_0000 + 32'(i) * 32'h0013_1071);
    cyc(0, 0, 1, 32'h0A00_0000);
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0);
    // sweep: new word every clock
    for (int i = 0; i < 40; i++) cyc(0, 1, 1, 32'h0100_0000 + 32'(i) * 32'h0080_0000);

    ctx = "R9";
    cyc(0, 1, 1, 32'hF000_0001);
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, 0);
    cyc(0, 1, 1, 32'h8000_0000);
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0);

    ctx = "R8";
    cyc(1, 1, 0, 0);
    cyc(0, 0, 0, 0);
    check("R8", int'(out_valid), 0);
    cyc(0, 0, 1, 32'h0777_7777);
    for (int i = 0; i < 30; i++) cyc(0, (i % 4) != 0, 0, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule